// File: doc/BRIEF.md
# Reconfigurable Lookup-Table Memory

This block models two 16-entry, one-bit lookup tables, called F and G, that serve as small read/write memory. A configuration input arranges the same 32 storage bits in one of three ways. It can act as a 16-word by 2-bit memory, as a 32-word by 1-bit memory, or as a 16-word by 1-bit memory with two read ports. In the 32-word arrangement the second data input is not data: it becomes the fifth address bit and picks the table.

Reads are combinational. Writes are triggered on the clock edge, with the write enable and the clock enable both required. A configuration bit can instead select level-sensitive writing. In that case an addressed entry follows its data input for as long as the write enable stays high. In the dual-port arrangement, the G table is a mirror of F. It is written at the same address with the same data, and it is read through its own independent address.

Top module: `dual_table_ram`

## Requirements
- R1: After reset all 32 stored bits are 0, so every read returns 0.
- R2: With cfg_org = 2'b00 (16x2), a write stores d0 into F and d1 into G at addr_a. rd_f shows F[addr_a] and rd_g shows G[addr_a].
- R3: With cfg_org = 2'b01 (32x1), d1 acts as the fifth address bit (0 selects F, 1 selects G). d0 is written into the selected table at addr_a, and the other table is left unchanged. rd_f shows the selected entry and rd_g is held at 0.
- R4: With cfg_org = 2'b10 or 2'b11 (dual-port 16x1), a write stores d0 into both F[addr_a] and G[addr_a]. rd_f shows F[addr_a] and rd_g shows G[addr_b], so the two copies stay identical.
- R5: In edge mode (cfg_level = 0), contents change only at a rising clock edge where we and ce are both 1. Any other combination leaves every bit unchanged.
- R6: In level mode (cfg_level = 1, with the 16x2 or 32x1 arrangement), while we is 1 the read outputs for addr_a follow d0 (and d1 for G in 16x2) in the same cycle, and ce is ignored. After we falls, the entry keeps the value it had at the last clock edge.
- R7: In the dual-port arrangement cfg_level is ignored, and writes remain edge-triggered with both enables required.
- R8: Reads are combinational. A change of addr_a or addr_b shows on the outputs within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all contents |
| cfg_org | input | 2 | Organisation: 00 16x2, 01 32x1, 1x dual-port 16x1 |
| cfg_level | input | 1 | 1 selects level-sensitive writing (not in dual-port) |
| we | input | 1 | Write enable |
| ce | input | 1 | Clock enable for edge-triggered writes |
| d0 | input | 1 | Write data for F and/or G |
| d1 | input | 1 | G write data (16x2) or table select (32x1) |
| addr_a | input | 4 | Write address and primary read address |
| addr_b | input | 4 | Mirror read address in dual-port mode |
| rd_f | output | 1 | Primary read data |
| rd_g | output | 1 | G data (16x2) or mirror read (dual-port), 0 in 32x1 |

## Verification
A wrong stored bit stays hidden until its address is read back. A read of that address shows the fault at once, in the same cycle, because the read path is combinational. The bench therefore reads each written cell right after the write. It also revisits cells after blocked writes, level-mode writes and arrangement changes. A mirror that diverges from F shows only through addr_b in dual-port mode, so dual-port reads deliberately use a different addr_b from addr_a.

// File: rtl/dual_table_ram.sv
module dual_table_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_org,
  input  logic          cfg_level,
  input  logic          we,
  input  logic          ce,
  input  logic          d0,
  input  logic          d1,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          rd_f,
  output logic          rd_g
);

  logic [DEPTH-1:0] tbl_f, tbl_g;

  wire is_dual  = cfg_org[1];
  wire is_wide  = (cfg_org == 2'b01);
  wire level_on = cfg_level & ~is_dual;
  wire wr_go    = we & (level_on | ce);
  wire follow   = level_on & we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_f <= '0;
      tbl_g <= '0;
    end else if (wr_go) begin
      if (is_dual) begin
        tbl_f[addr_a] <= d0;
        tbl_g[addr_a] <= d0;
      end else if (is_wide) begin
        if (d1) tbl_g[addr_a] <= d0;
        else    tbl_f[addr_a] <= d0;
      end else begin
        tbl_f[addr_a] <= d0;
        tbl_g[addr_a] <= d1;
      end
    end
  end

  wire f_cell = tbl_f[addr_a];
  wire g_cell = tbl_g[addr_a];
  wire m_cell = tbl_g[addr_b];

  assign rd_f = is_dual ? f_cell
              : follow  ? d0
              : (is_wide && d1) ? g_cell : f_cell;

  assign rd_g = is_dual ? m_cell
              : is_wide ? 1'b0
              : follow  ? d1 : g_cell;

  AST_PAIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_org == 2'b00 && wr_go) |=> (tbl_f[$past(addr_a)] == $past(d0) && tbl_g[$past(addr_a)] == $past(d1))); // R2

  AST_WIDE_OTHER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wide && wr_go && !d1) |=> $stable(tbl_g)); // R3

  AST_MIRROR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual && wr_go) |=> (tbl_f[$past(addr_a)] == tbl_g[$past(addr_a)])); // R4

  AST_NO_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_on && !(we && ce)) |=> ($stable(tbl_f) && $stable(tbl_g))); // R5

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && we && cfg_org == 2'b00) |-> (rd_f == d0 && rd_g == d1)); // R6

  AST_DUAL_IGNORES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual && cfg_level && we && !ce) |=> ($stable(tbl_f) && $stable(tbl_g))); // R7

endmodule

// File: tb/dual_table_ram_bench.sv
module dual_table_ram_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_org = 2'b00;
  logic cfg_level = 1'b0, we = 1'b0, ce = 1'b0, d0 = 1'b0, d1 = 1'b0;
  logic [3:0] addr_a = '0, addr_b = '0;
  logic rd_f, rd_g;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [1:0] exp; string tag; } item_t;
  item_t sb[$];
  event sample_ev;

  logic [15:0] mf = '0, mg = '0;

  always #4 clk = ~clk;

  dual_table_ram u_dual_table_ram (
    .clk(clk), .rst_n(rst_n), .cfg_org(cfg_org), .cfg_level(cfg_level),
    .we(we), .ce(ce), .d0(d0), .d1(d1), .addr_a(addr_a), .addr_b(addr_b),
    .rd_f(rd_f), .rd_g(rd_g)
  );

  function automatic logic [1:0] model_out();
    logic lvl_follow;
    lvl_follow = cfg_level && we && !cfg_org[1];
    if (cfg_org[1])          return {mf[addr_a], mg[addr_b]};
    else if (cfg_org == 2'b01)
      return {lvl_follow ? d0 : (d1 ? mg[addr_a] : mf[addr_a]), 1'b0};
    else
      return lvl_follow ? {d0, d1} : {mf[addr_a], mg[addr_a]};
  endfunction

  task automatic step(input logic [1:0] org, input logic lvl, input logic w,
                      input logic c, input logic v0, input logic v1,
                      input logic [3:0] a, input logic [3:0] b, input string tag);
    item_t it;
    bit go;
    @(negedge clk);
    cfg_org = org; cfg_level = lvl; we = w; ce = c;
    d0 = v0; d1 = v1; addr_a = a; addr_b = b;
    #1;
    it.exp = model_out();
    it.tag = tag;
    sb.push_back(it);
    -> sample_ev;
    @(posedge clk);
    go = (lvl && !org[1]) ? w : (w && c);
    if (go) begin
      if (org[1]) begin mf[a] = v0; mg[a] = v0; end
      else if (org == 2'b01) begin
        if (v1) mg[a] = v0; else mf[a] = v0;
      end else begin mf[a] = v0; mg[a] = v1; end
    end
  endtask

  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if ({rd_f, rd_g} !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got rd_f/rd_g=%b expected %b", it.tag, {rd_f, rd_g}, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    step(2'b00, 0, 0, 0, 0, 0, 4'd0, 4'd0, "R1 addr0");
    step(2'b00, 0, 0, 0, 0, 0, 4'd15, 4'd0, "R1 addr15");
    step(2'b10, 0, 0, 0, 0, 0, 4'd6, 4'd9, "R1 dual read");
    // R2 16x2 writes and reads
    step(2'b00, 0, 1, 1, 1, 0, 4'd3, 4'd0, "R2 write a3");
    step(2'b00, 0, 1, 1, 0, 1, 4'd5, 4'd0, "R2 write a5");
    step(2'b00, 0, 1, 1, 1, 1, 4'd15, 4'd0, "R2 write a15");
    step(2'b00, 0, 0, 0, 0, 0, 4'd3, 4'd0, "R2 read a3");
    step(2'b00, 0, 0, 0, 0, 0, 4'd5, 4'd0, "R8 read a5");
    step(2'b00, 0, 0, 0, 0, 0, 4'd15, 4'd0, "R8 read a15");
    // R5 blocked writes
    step(2'b00, 0, 1, 0, 0, 1, 4'd3, 4'd0, "R5 we without ce");
    step(2'b00, 0, 0, 1, 0, 1, 4'd3, 4'd0, "R5 ce without we");
    step(2'b00, 0, 0, 0, 0, 0, 4'd3, 4'd0, "R5 a3 unchanged");
    // R3 32x1
    step(2'b01, 0, 1, 1, 1, 0, 4'd2, 4'd0, "R3 write F2");
    step(2'b01, 0, 1, 1, 0, 1, 4'd2, 4'd0, "R3 write G2");
    step(2'b01, 0, 0, 0, 0, 0, 4'd2, 4'd0, "R3 read F2");
    step(2'b01, 0, 0, 0, 0, 1, 4'd2, 4'd0, "R3 read G2");
    step(2'b01, 0, 1, 1, 1, 1, 4'd8, 4'd0, "R3 write G8");
    step(2'b00, 0, 0, 0, 0, 0, 4'd8, 4'd0, "R3 F8 untouched via 16x2");
    step(2'b00, 0, 0, 0, 0, 0, 4'd2, 4'd0, "R3 pair view a2");
    // R4 dual-port
    step(2'b10, 0, 1, 1, 1, 0, 4'd7, 4'd0, "R4 write a7");
    step(2'b10, 0, 0, 0, 0, 0, 4'd7, 4'd7, "R4 mirror a7");
    step(2'b10, 0, 0, 0, 0, 0, 4'd7, 4'd5, "R4 mirror b5");
    step(2'b11, 0, 1, 1, 0, 1, 4'd5, 4'd7, "R4 write a5 org11");
    step(2'b11, 0, 0, 0, 0, 0, 4'd5, 4'd15, "R4 read b15");
    // R7 dual ignores level mode
    step(2'b10, 1, 1, 0, 0, 0, 4'd7, 4'd7, "R7 level+we no ce");
    step(2'b10, 1, 0, 0, 0, 0, 4'd7, 4'd7, "R7 a7 still set");
    step(2'b10, 1, 1, 1, 0, 0, 4'd7, 4'd7, "R7 edge write clears");
    step(2'b10, 0, 0, 0, 0, 0, 4'd7, 4'd7, "R7 a7 cleared");
    // R6 level mode
    step(2'b00, 1, 1, 0, 1, 1, 4'd9, 4'd0, "R6 follow 16x2");
    step(2'b00, 1, 0, 0, 0, 0, 4'd9, 4'd0, "R6 held a9");
    step(2'b01, 1, 1, 0, 1, 0, 4'd10, 4'd0, "R6 follow 32x1");
    step(2'b01, 1, 0, 0, 0, 0, 4'd10, 4'd0, "R6 held F10");
    step(2'b01, 1, 0, 0, 0, 1, 4'd10, 4'd0, "R6 G10 untouched");
    step(2'b00, 0, 0, 0, 0, 0, 4'd0, 4'd0, "R8 idle");
    #20;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule